// File: doc/BRIEF.md
# Cascaded Programmable Clock-Enable Divider Bank

The block turns one fast input clock into a set of divided clock-enable pulses. One 32-bit control word sets every ratio. A base divider makes the double-rate system enable from the input clock. The bus, peripheral, JPEG, camera and security enables are then counted down from that base enable. Two more dividers, one for the PLL-derived clock and one for the media-codec clock, count straight from the input clock. Each output is a one-cycle enable pulse in the fast clock domain. A divider whose field holds N produces one pulse for every N+1 cycles of its source. Downstream clock-gating cells or enable-qualified logic use these pulses.

Software writes the whole word through a single-cycle write strobe and reads it back on a combinational read bus. Some fields are restricted. The JPEG and peripheral ratios must be odd, so that the division is even. The security ratio may be only 1 or 3. A write that breaks a restriction is still stored and still drives the divider. It also sets an error flag that stays set until reset. Software must also keep the resulting frequencies within the limits of the chip: about 266 MHz for the base, 133 MHz for the bus, camera and codec clocks, and 66 MHz for the peripheral, JPEG and security clocks. A divider takes a new ratio only when its counter wraps. The pulse in progress therefore finishes at its old length, and the period settles to the new value one period later.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, `rd_data` reads 0x0105_1000 and `cfg_err` is 0.
- R2: A write stores the non-reserved bits, and `rd_data` shows them from the next cycle on. The field positions are: codec [31:28], JPEG [27:24], camera [23:20], security [19:18], peripheral [15:12], base [11:9], bus [8], PLL [4].
- R3: Reserved bits [17:16] always read 2'b01, and bits [7:5] and [3:0] always read 0, whatever is written to them.
- R4: `en_base` pulses once every (base field + 1) input clock cycles. A field of 0 gives a pulse on every cycle.
- R5: The bus, peripheral, JPEG, camera and security enables pulse once every (base+1)*(own field+1) input cycles, and each of their pulses falls in a cycle where `en_base` is high.
- R6: `en_codec` pulses every (codec field + 1) input cycles and `en_pll` every (PLL field + 1) input cycles.
- R7: A write with an even JPEG field, an even peripheral field or a security field of 0 or 2 is stored as written and sets `cfg_err` in the next cycle.
- R8: Once set, `cfg_err` stays 1 until reset, even through later legal writes.
- R9: A write with legal restricted fields leaves a clear `cfg_err` clear.
- R10: A ratio change does not cut short the period in progress. The next pulse arrives at the old period, and the new period applies from that pulse on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; all logic and enables refer to it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, reserved bits forced |
| cfg_err | output | 1 | Sticky flag for an illegal value in a restricted field |
| en_base | output | 1 | Base (double-rate system) clock enable |
| en_bus | output | 1 | System bus clock enable |
| en_periph | output | 1 | Peripheral clock enable |
| en_jpeg | output | 1 | JPEG unit clock enable |
| en_cam | output | 1 | Camera unit clock enable |
| en_secur | output | 1 | Security unit clock enable |
| en_codec | output | 1 | Media-codec clock enable |
| en_pll | output | 1 | PLL-derived divided clock enable |

## Verification
The hardest case to reach is a ratio change that lands partway through a period. Only the exact cycle of the write relative to the counter phase shows whether the old period is kept. The stimulus first sets the base ratio to its largest value. It then waits for an `en_base` pulse and writes ratio 0 two cycles later. It checks that the next pulse still comes eight cycles after the previous one and that pulses then occur on every cycle. The period sweep covers every base ratio against a set of legal field mixes. Before each measurement it lets three pulses pass, so that the changes in the base and child dividers have settled.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    localparam int WORD_W   = 32;
    localparam int CODEC_W  = 4;
    localparam int JPEG_W   = 4;
    localparam int CAM_W    = 4;
    localparam int SECUR_W  = 2;
    localparam int PERIPH_W = 4;
    localparam int BASE_W   = 3;
    localparam int BUS_W    = 1;
    localparam int PLL_W    = 1;
    localparam int SUB_W    = 4;
    localparam int N_SUB    = 5;

    // control word, MSB first; field positions are fixed by software
    typedef struct packed {
        logic [CODEC_W-1:0]  codec;
        logic [JPEG_W-1:0]   jpeg;
        logic [CAM_W-1:0]    cam;
        logic [SECUR_W-1:0]  secur;
        logic [1:0]          rsv_hi;
        logic [PERIPH_W-1:0] periph;
        logic [BASE_W-1:0]   base;
        logic [BUS_W-1:0]    bus;
        logic [2:0]          rsv_mid;
        logic [PLL_W-1:0]    pll;
        logic [3:0]          rsv_lo;
    } ctrl_t;

    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0105_1000;
    localparam logic [1:0]        RSV_HI_VAL = 2'b01;

    function automatic ctrl_t force_reserved(input ctrl_t c);
        ctrl_t r;
        r         = c;
        r.rsv_hi  = RSV_HI_VAL;
        r.rsv_mid = '0;
        r.rsv_lo  = '0;
        return r;
    endfunction

    // restricted fields: odd JPEG, odd peripheral, security in {1,3}
    function automatic logic ctrl_illegal(input ctrl_t c);
        return !c.jpeg[0] || !c.periph[0] || !c.secur[0];
    endfunction

endpackage

// File: rtl/cdb_cfg_reg.sv
module cdb_cfg_reg
    import cdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             cfg,
    output logic              err
);

    ctrl_t cfg_q;
    logic  err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= ctrl_t'(CTRL_RESET);
            err_q <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= force_reserved(ctrl_t'(wr_data));
            err_q <= err_q | ctrl_illegal(ctrl_t'(wr_data));
        end
    end

    assign cfg = cfg_q;
    assign err = err_q;

endmodule

// File: rtl/cdb_div.sv
module cdb_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         src_en,
    input  logic [W-1:0] ratio,
    output logic         tick
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;   // ratio in force for the current period
    logic         wrap;

    assign wrap = (cnt_q == act_q);
    assign tick = src_en && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (src_en) begin
            if (wrap) begin
                cnt_q <= '0;
                act_q <= ratio;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import cdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              cfg_err,
    output logic              en_base,
    output logic              en_bus,
    output logic              en_periph,
    output logic              en_jpeg,
    output logic              en_cam,
    output logic              en_secur,
    output logic              en_codec,
    output logic              en_pll
);

    ctrl_t            cfg;
    logic [SUB_W-1:0] sub_ratio [N_SUB];
    logic [N_SUB-1:0] sub_tick;

    cdb_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .err     (cfg_err)
    );

    assign rd_data = cfg;

    cdb_div #(.W(BASE_W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .src_en (1'b1),
        .ratio  (cfg.base),
        .tick   (en_base)
    );

    assign sub_ratio[0] = SUB_W'(cfg.bus);
    assign sub_ratio[1] = SUB_W'(cfg.periph);
    assign sub_ratio[2] = SUB_W'(cfg.jpeg);
    assign sub_ratio[3] = SUB_W'(cfg.cam);
    assign sub_ratio[4] = SUB_W'(cfg.secur);

    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
        cdb_div #(.W(SUB_W)) u_div (
            .clk    (clk),
            .rst    (rst),
            .src_en (en_base),
            .ratio  (sub_ratio[g]),
            .tick   (sub_tick[g])
        );
    end

    assign en_bus    = sub_tick[0];
    assign en_periph = sub_tick[1];
    assign en_jpeg   = sub_tick[2];
    assign en_cam    = sub_tick[3];
    assign en_secur  = sub_tick[4];

    cdb_div #(.W(CODEC_W)) u_codec (
        .clk    (clk),
        .rst    (rst),
        .src_en (1'b1),
        .ratio  (cfg.codec),
        .tick   (en_codec)
    );

    cdb_div #(.W(PLL_W)) u_pll (
        .clk    (clk),
        .rst    (rst),
        .src_en (1'b1),
        .ratio  (cfg.pll),
        .tick   (en_pll)
    );

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
    import cdb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              cfg_err,
    input logic              en_base,
    input logic              en_bus,
    input logic              en_periph,
    input logic              en_jpeg,
    input logic              en_cam,
    input logic              en_secur,
    input logic              en_codec,
    input logic              en_pll
);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == CTRL_RESET) && !cfg_err);

    assert_rsv_const_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[17:16] == 2'b01) && (rd_data[7:5] == 3'b000) && (rd_data[3:0] == 4'h0));

    assert_write_stored_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[31:18] == $past(wr_data[31:18])) &&
                  (rd_data[15:8] == $past(wr_data[15:8])) &&
                  (rd_data[4] == $past(wr_data[4])));

    assert_bus_in_base_R5: assert property (@(posedge clk) disable iff (rst)
        en_bus |-> en_base);

    assert_periph_in_base_R5: assert property (@(posedge clk) disable iff (rst)
        en_periph |-> en_base);

    assert_jpeg_in_base_R5: assert property (@(posedge clk) disable iff (rst)
        en_jpeg |-> en_base);

    assert_cam_in_base_R5: assert property (@(posedge clk) disable iff (rst)
        en_cam |-> en_base);

    assert_secur_in_base_R5: assert property (@(posedge clk) disable iff (rst)
        en_secur |-> en_base);

    assert_err_on_illegal_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_illegal(ctrl_t'(wr_data))) |=> cfg_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_legal_keeps_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_err && wr_en && !ctrl_illegal(ctrl_t'(wr_data))) |=> !cfg_err);

    assert_idle_keeps_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_err && !wr_en) |=> !cfg_err);

endmodule

bind clkdiv_bank clkdiv_bank_chk chk_i (.*);

// File: tb/clkdiv_bank_tb_top.sv
module clkdiv_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cfg_err;
    logic        en_base, en_bus, en_periph, en_jpeg, en_cam, en_secur, en_codec, en_pll;
    logic [7:0]  en_vec;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkdiv_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_err(cfg_err),
        .en_base(en_base), .en_bus(en_bus), .en_periph(en_periph),
        .en_jpeg(en_jpeg), .en_cam(en_cam), .en_secur(en_secur),
        .en_codec(en_codec), .en_pll(en_pll)
    );

    assign en_vec = {en_pll, en_codec, en_secur, en_cam, en_jpeg, en_periph, en_bus, en_base};

    function automatic logic [31:0] mk(input int codec, input int jpeg, input int cam,
                                       input int secur, input int periph, input int base,
                                       input int bus, input int pll);
        return {codec[3:0], jpeg[3:0], cam[3:0], secur[1:0], 2'b01, periph[3:0],
                base[2:0], bus[0], 3'b000, pll[0], 4'h0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // gap in cycles between the 3rd and 4th pulse seen on output b
    task automatic period(input int b, output int p);
        int seen = 0;
        int c = 0;
        while (seen < 4) begin
            @(negedge clk);
            c++;
            if (en_vec[b]) begin
                seen++;
                if (seen == 3) c = 0;
            end
        end
        p = c;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int p;
        int zeros;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rd_data == 32'h0105_1000, "R1 reset value", rd_data, 32'h0105_1000);
        check(cfg_err == 1'b0, "R1 reset err", cfg_err, 0);

        // reserved bits and readback
        wr(32'hFFFF_FFFF);
        check(rd_data == 32'hFFFD_FF10, "R3 reserved forced", rd_data, 32'hFFFD_FF10);
        check(cfg_err == 1'b0, "R9 all-ones legal", cfg_err, 0);
        w = mk(9, 5, 6, 3, 7, 2, 1, 1);
        wr(w);
        check(rd_data == w, "R2 readback", rd_data, w);

        // ratio change in mid period
        wr(mk(0, 1, 0, 1, 1, 7, 0, 0));
        do @(negedge clk); while (!en_base);
        @(negedge clk);
        zeros = en_base ? 1 : 0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = mk(0, 1, 0, 1, 1, 0, 0, 0);
        zeros += en_base ? 1 : 0;
        @(negedge clk);
        wr_en = 1'b0;
        zeros += en_base ? 1 : 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            zeros += en_base ? 1 : 0;
        end
        check(zeros == 0, "R10 no early pulse", zeros, 0);
        @(negedge clk);
        check(en_base == 1'b1, "R10 pulse at old period", en_base, 1);
        @(negedge clk);
        check(en_base == 1'b1, "R10 new ratio after wrap", en_base, 1);

        // period sweep
        for (int x = 0; x < 8; x++) begin
            for (int k = 0; k < 8; k++) begin
                int pe, jp, cm, sc, bs, cd, pl;
                pe = 2 * k + 1;
                jp = 15 - 2 * k;
                cm = k;
                sc = (k & 2) ? 3 : 1;
                bs = k & 1;
                cd = 2 * k;
                pl = (k >> 2) & 1;
                wr(mk(cd, jp, cm, sc, pe, x, bs, pl));
                period(0, p); check(p == x + 1, "R4 base period", p, x + 1);
                period(1, p); check(p == (x + 1) * (bs + 1), "R5 bus period", p, (x + 1) * (bs + 1));
                period(2, p); check(p == (x + 1) * (pe + 1), "R5 periph period", p, (x + 1) * (pe + 1));
                period(3, p); check(p == (x + 1) * (jp + 1), "R5 jpeg period", p, (x + 1) * (jp + 1));
                period(4, p); check(p == (x + 1) * (cm + 1), "R5 cam period", p, (x + 1) * (cm + 1));
                period(5, p); check(p == (x + 1) * (sc + 1), "R5 secur period", p, (x + 1) * (sc + 1));
                period(6, p); check(p == cd + 1, "R6 codec period", p, cd + 1);
                period(7, p); check(p == pl + 1, "R6 pll period", p, pl + 1);
            end
        end
        check(cfg_err == 1'b0, "R9 sweep legal", cfg_err, 0);

        // illegal values
        w = mk(0, 2, 0, 1, 1, 0, 0, 0);
        wr(w);
        check(rd_data == w, "R7 even jpeg stored", rd_data, w);
        check(cfg_err == 1'b1, "R7 even jpeg flag", cfg_err, 1);
        period(3, p); check(p == 3, "R7 even jpeg used", p, 3);
        wr(mk(0, 1, 0, 1, 1, 0, 0, 0));
        check(cfg_err == 1'b1, "R8 sticky after legal write", cfg_err, 1);
        do_reset();
        check(cfg_err == 1'b0, "R8 cleared by reset", cfg_err, 0);
        check(rd_data == 32'h0105_1000, "R1 value after reset", rd_data, 32'h0105_1000);
        w = mk(0, 1, 0, 2, 1, 0, 0, 0);
        wr(w);
        check(rd_data == w, "R7 secur 2 stored", rd_data, w);
        check(cfg_err == 1'b1, "R7 secur 2 flag", cfg_err, 1);
        do_reset();
        wr(mk(0, 1, 0, 0, 1, 0, 0, 0));
        check(cfg_err == 1'b1, "R7 secur 0 flag", cfg_err, 1);
        do_reset();
        wr(mk(0, 1, 0, 1, 4, 0, 0, 0));
        check(cfg_err == 1'b1, "R7 even periph flag", cfg_err, 1);
        do_reset();
        wr(mk(3, 7, 2, 3, 5, 1, 1, 1));
        check(cfg_err == 1'b0, "R9 legal after reset", cfg_err, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule